// File: doc/BRIEF.md
# Dual-Style Host Bus Slave

This block is the host-facing front end of a display-link serializer. A microprocessor attaches to it over a 16-bit parallel bus. A static pin selects one of two bus styles. In split-strobe style the host uses separate active-low read and write strobes. In enable-strobe style the host uses one active-high enable strobe and a direction line. The same two bus pins carry either meaning. Every bus input is oversampled in the fast system clock through a synchronizer chain. Strobe edges are found by comparing consecutive synchronized samples.

A write cycle produces one word on a valid/ready output: 16 data bits plus a flag that marks a command (address) cycle. A write that arrives while that output is stalled is dropped, and a sticky overflow flag is set. Read data returned from the far end of the link is held in a register and driven on the bus while a host read is qualified. The arrival of that data raises an interrupt. The interrupt drops once the host has completed two read cycles.

Three state machines do the work:
- **Bus cycle machine.** States `CYC_IDLE`, `CYC_WRITE` and `CYC_READ`.
  - Transitions: idle→write on a write qualifier; idle→read on a read qualifier; write→write and read→read while the qualifier holds.
  - write→idle when the write qualifier drops. This captures the word, except for an abort.
  - The abort: in enable-strobe style, the direction line rises while the enable is high and the chip is selected. The machine leaves write without a word.
  - read→idle when the read qualifier drops. This counts as one completed read.
- **Interrupt machine.** States `IRQ_CLEAR`, `IRQ_PEND` and `IRQ_HALF`.
  - Any state goes to pending on returned data.
  - pending→half on the first completed read.
  - half→clear on the second completed read.
- **Output slot machine.** States `SLOT_EMPTY` and `SLOT_FULL`.
  - empty→full on a capture.
  - full→empty on an accept with no new capture.
  - full→full on an accept together with a new capture, or while stalled.

Top module: `hostbus_slave`

## Requirements
- R1: Split-strobe style (`mode_split`=1), writing. A write is a cycle with `bus_dir` (the write strobe) low and both chip selects low. It is captured when the first of two events occurs: `bus_dir` rises, or the chip select deasserts. Data and tag come from the bus as it stood before that edge. Later bus changes are ignored. The word appears on `wr_valid` within SYNC_STAGES+2 clock cycles of the edge.
- R2: Enable-strobe style (`mode_split`=0), writing. A write is a cycle with `bus_dir` low (write; high means read) while `bus_strb` (the enable) is high and the chip is selected. It is captured when the enable falls.
- R3: Enable-strobe style with the enable held high. The write is captured when the chip select deasserts.
- R4: `bus_dc`=1 marks a data cycle and gives `wr_cmd`=0. `bus_dc`=0 marks a command cycle and gives `wr_cmd`=1.
- R5: A cycle counts only while both `cs_a_n` and `cs_b_n` are low. If either is high, strobes produce no word, no bus drive and no read count.
- R6: Split-strobe style, reading. `bus_d_oe` is high only while `bus_strb` (the read strobe) is low, `bus_dir` is high and the chip is selected, as seen SYNC_STAGES+1 cycles earlier. `bus_d_out` carries the most recent `rsp_data`.
- R7: Enable-strobe style, reading. `bus_d_oe` is high only while the enable is high, `bus_dir` is high and the chip is selected, with the same lag as R6.
- R8: `irq` is high in the cycle after `rsp_valid`. It stays high through the first completed host read and is low after the second. A new `rsp_valid` restarts the count.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_data` and `wr_cmd` hold steady. A word is consumed on a cycle where both are high.
- R10: A capture while `wr_valid`=1 and `wr_ready`=0 sets `wr_ovf`. The flag stays set until reset. The new word is discarded and the held word is unchanged.
- R11: After reset, `wr_valid`, `irq`, `wr_ovf` and `bus_d_oe` are 0 and `bus_d_out` is 0.
- R12: In enable-strobe style, `bus_dir` rising while the enable is high and the chip is selected aborts the write. No word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_split | input | 1 | Static style select: 1 split strobes, 0 enable plus direction |
| bus_strb | input | 1 | Read strobe (active low) or enable (active high) |
| bus_dir | input | 1 | Write strobe (active low) or direction (1 read, 0 write) |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| bus_dc | input | 1 | 1 data cycle, 0 command cycle |
| bus_d_in | input | 16 | Data bus as seen from the host |
| bus_d_out | output | 16 | Read data presented to the bus |
| bus_d_oe | output | 1 | Bus drive enable for read cycles |
| rsp_valid | input | 1 | Read data from the far end is ready (one-cycle pulse) |
| rsp_data | input | 16 | Read data from the far end |
| irq | output | 1 | Read-data-ready interrupt to the host |
| wr_valid | output | 1 | Captured write word is pending |
| wr_ready | input | 1 | Downstream accepts the pending word |
| wr_data | output | 16 | Captured write data |
| wr_cmd | output | 1 | Captured word came from a command cycle |
| wr_ovf | output | 1 | Sticky overflow: a write was dropped |

## Verification
- **Bus cycle machine.** A machine that stays in read after the strobes release shows `bus_d_oe` high past the SYNC_STAGES+1 lag. It is caught on the first cycle beyond that lag.
- **Write capture.** A capture on the wrong edge, or taken from the wrong sample, shows as a word with stale or garbage data on the output port. The bench changes the bus immediately after the first qualifying edge. A word from a deselected or aborted cycle shows as an unexpected `wr_valid` within four cycles.
- **Interrupt machine.** A wrong read count shows as `irq` falling after the first read instead of the second.
- **Output slot.** A slot that overwrites while stalled shows as a changed `wr_data` the very next cycle.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    localparam int HBS_DATA_W      = 16;
    localparam int HBS_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_WRITE,
        CYC_READ
    } cyc_state_e;

    typedef enum logic [1:0] {
        IRQ_CLEAR,
        IRQ_PEND,
        IRQ_HALF
    } irq_state_e;

    typedef enum logic {
        SLOT_EMPTY,
        SLOT_FULL
    } slot_state_e;

    typedef struct packed {
        logic strb;
        logic dir;
        logic cs_a_n;
        logic cs_b_n;
    } ctrl_pins_t;

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // chain of flops, stage 0 samples the pin
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= RST_VAL;
                else        r <= g_stage[g-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/hbs_cycle_fsm.sv
module hbs_cycle_fsm
    import hbs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_split,
    input  ctrl_pins_t        pins,
    input  logic              dc_s,
    input  logic [DATA_W-1:0] d_s,
    output logic              wr_evt,
    output logic              wr_evt_cmd,
    output logic [DATA_W-1:0] wr_evt_data,
    output logic              rd_done,
    output logic              rd_drive
);

    cyc_state_e        state_q, state_d;
    logic              cs_sel;
    logic              wr_qual;
    logic              rd_qual;
    logic              wr_abort;
    logic              dc_hold;
    logic [DATA_W-1:0] d_hold;

    // qualifiers built from synchronized pins
    always_comb begin
        cs_sel = ~pins.cs_a_n & ~pins.cs_b_n;
        if (mode_split) begin
            wr_qual  = cs_sel & ~pins.dir;
            rd_qual  = cs_sel & ~pins.strb & pins.dir;
            wr_abort = 1'b0;
        end else begin
            wr_qual  = cs_sel & pins.strb & ~pins.dir;
            rd_qual  = cs_sel & pins.strb & pins.dir;
            // direction flipped to read with enable still high
            wr_abort = rd_qual;
        end
    end

    // previous bus sample: the value that stood before a terminating edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dc_hold <= 1'b1;
            d_hold  <= '0;
        end else begin
            dc_hold <= dc_s;
            d_hold  <= d_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CYC_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE: begin
                if (wr_qual)      state_d = CYC_WRITE;
                else if (rd_qual) state_d = CYC_READ;
            end
            CYC_WRITE: begin
                if (!wr_qual) state_d = CYC_IDLE;
            end
            CYC_READ: begin
                if (!rd_qual) state_d = CYC_IDLE;
            end
            default: state_d = CYC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_evt      = (state_q == CYC_WRITE) && !wr_qual && !wr_abort;
        wr_evt_cmd  = ~dc_hold;
        wr_evt_data = d_hold;
        rd_done     = (state_q == CYC_READ) && !rd_qual;
        rd_drive    = (state_q == CYC_READ);
    end

endmodule

// File: rtl/hbs_irq_fsm.sv
module hbs_irq_fsm
    import hbs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              rd_done,
    output logic              irq,
    output logic [DATA_W-1:0] rd_word
);

    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_CLEAR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rd_word <= '0;
        else if (rsp_valid) rd_word <= rsp_data;
    end

    always_comb begin
        state_d = state_q;
        if (rsp_valid) begin
            state_d = IRQ_PEND;
        end else begin
            unique case (state_q)
                IRQ_CLEAR: state_d = IRQ_CLEAR;
                IRQ_PEND:  if (rd_done) state_d = IRQ_HALF;
                IRQ_HALF:  if (rd_done) state_d = IRQ_CLEAR;
                default:   state_d = IRQ_CLEAR;
            endcase
        end
    end

    always_comb begin
        irq = (state_q != IRQ_CLEAR);
    end

endmodule

// File: rtl/hbs_wr_slot.sv
module hbs_wr_slot
    import hbs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic              evt_cmd,
    input  logic [DATA_W-1:0] evt_data,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic              wr_cmd,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_ovf
);

    slot_state_e state_q, state_d;
    logic        load;
    logic        ovf_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (evt) state_d = SLOT_FULL;
            SLOT_FULL:  if (wr_ready && !evt) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_comb begin
        load     = evt && ((state_q == SLOT_EMPTY) || wr_ready);
        ovf_set  = evt && (state_q == SLOT_FULL) && !wr_ready;
        wr_valid = (state_q == SLOT_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cmd  <= 1'b0;
            wr_data <= '0;
            wr_ovf  <= 1'b0;
        end else begin
            if (load) begin
                wr_cmd  <= evt_cmd;
                wr_data <= evt_data;
            end
            if (ovf_set) wr_ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
    import hbs_pkg::*;
#(
    parameter int DATA_W      = HBS_DATA_W,
    parameter int SYNC_STAGES = HBS_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_split,
    input  logic              bus_strb,
    input  logic              bus_dir,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              bus_dc,
    input  logic [DATA_W-1:0] bus_d_in,
    output logic [DATA_W-1:0] bus_d_out,
    output logic              bus_d_oe,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              irq,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_cmd,
    output logic              wr_ovf
);

    localparam int CTRL_W = $bits(ctrl_pins_t);
    localparam int WORD_W = DATA_W + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [WORD_W-1:0] word_q;
    ctrl_pins_t        pins_s;
    logic              wr_evt;
    logic              wr_evt_cmd;
    logic [DATA_W-1:0] wr_evt_data;
    logic              rd_done;
    logic              rd_drive;

    hbs_sync #(
        .W       (CTRL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({CTRL_W{1'b1}})
    ) u_sync_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_strb, bus_dir, cs_a_n, cs_b_n}),
        .q     (ctrl_q)
    );

    hbs_sync #(
        .W       (WORD_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, {DATA_W{1'b0}}})
    ) u_sync_word (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_dc, bus_d_in}),
        .q     (word_q)
    );

    assign pins_s = ctrl_pins_t'(ctrl_q);

    hbs_cycle_fsm #(.DATA_W(DATA_W)) u_cycle (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_split  (mode_split),
        .pins        (pins_s),
        .dc_s        (word_q[DATA_W]),
        .d_s         (word_q[DATA_W-1:0]),
        .wr_evt      (wr_evt),
        .wr_evt_cmd  (wr_evt_cmd),
        .wr_evt_data (wr_evt_data),
        .rd_done     (rd_done),
        .rd_drive    (rd_drive)
    );

    hbs_irq_fsm #(.DATA_W(DATA_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rd_done   (rd_done),
        .irq       (irq),
        .rd_word   (bus_d_out)
    );

    hbs_wr_slot #(.DATA_W(DATA_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (wr_evt),
        .evt_cmd  (wr_evt_cmd),
        .evt_data (wr_evt_data),
        .wr_ready (wr_ready),
        .wr_valid (wr_valid),
        .wr_cmd   (wr_cmd),
        .wr_data  (wr_data),
        .wr_ovf   (wr_ovf)
    );

    assign bus_d_oe = rd_drive;

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
    parameter int DATA_W = 16,
    parameter int STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_split,
    input logic              bus_strb,
    input logic              bus_dir,
    input logic              cs_a_n,
    input logic              cs_b_n,
    input logic              bus_d_oe,
    input logic              rsp_valid,
    input logic              irq,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_cmd,
    input logic              wr_ovf
);

    logic       rd_raw_split;
    logic       rd_raw_enab;
    logic [STAGES:0] hist_split;
    logic [STAGES:0] hist_enab;

    assign rd_raw_split = ~cs_a_n & ~cs_b_n & ~bus_strb & bus_dir;
    assign rd_raw_enab  = ~cs_a_n & ~cs_b_n &  bus_strb & bus_dir;

    // pin history, so no deep $past is needed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_split <= '0;
            hist_enab  <= '0;
        end else begin
            hist_split <= {hist_split[STAGES-1:0], rd_raw_split};
            hist_enab  <= {hist_enab[STAGES-1:0],  rd_raw_enab};
        end
    end

    assert_oe_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_d_oe && mode_split) |-> hist_split[STAGES]);

    assert_oe_enab_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_d_oe && !mode_split) |-> hist_enab[STAGES]);

    assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> irq);

    assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> !$past(rsp_valid));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_cmd)));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ovf |=> wr_ovf);

    assert_reset_R11: assert property (@(posedge clk)
        !rst_n |=> (!wr_valid && !irq && !wr_ovf && !bus_d_oe));

endmodule

bind hostbus_slave hbs_checker #(
    .DATA_W (DATA_W),
    .STAGES (SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_split (mode_split),
    .bus_strb   (bus_strb),
    .bus_dir    (bus_dir),
    .cs_a_n     (cs_a_n),
    .cs_b_n     (cs_b_n),
    .bus_d_oe   (bus_d_oe),
    .rsp_valid  (rsp_valid),
    .irq        (irq),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_data    (wr_data),
    .wr_cmd     (wr_cmd),
    .wr_ovf     (wr_ovf)
);

// File: tb/hostbus_slave_tb_top.sv
module hostbus_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_split = 1'b1;
    logic          bus_strb = 1'b1;
    logic          bus_dir = 1'b1;
    logic          cs_a_n = 1'b1;
    logic          cs_b_n = 1'b1;
    logic          bus_dc = 1'b1;
    logic [DW-1:0] bus_d_in = '0;
    logic [DW-1:0] bus_d_out;
    logic          bus_d_oe;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          irq;
    logic          wr_valid;
    logic          wr_ready = 1'b1;
    logic [DW-1:0] wr_data;
    logic          wr_cmd;
    logic          wr_ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [DW:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_split (mode_split),
        .bus_strb   (bus_strb),
        .bus_dir    (bus_dir),
        .cs_a_n     (cs_a_n),
        .cs_b_n     (cs_b_n),
        .bus_dc     (bus_dc),
        .bus_d_in   (bus_d_in),
        .bus_d_out  (bus_d_out),
        .bus_d_oe   (bus_d_oe),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .irq        (irq),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .wr_data    (wr_data),
        .wr_cmd     (wr_cmd),
        .wr_ovf     (wr_ovf)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_word(input logic dc, input logic [DW-1:0] v, input string tag);
        exp_q.push_back({~dc, v});
        tag_q.push_back(tag);
    endtask

    // monitor: pops expected words as the design hands them over
    always @(negedge clk) begin : mon
        logic [DW:0] e;
        string       t;
        if (rst_n && wr_valid && wr_ready) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R5/R12 unexpected word actual=%h expected=none", {wr_cmd, wr_data});
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({wr_cmd, wr_data} !== e) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", t, {wr_cmd, wr_data}, e);
                end
            end
        end
    end

    // split-strobe write ended by the write strobe rising
    task automatic w_split(input logic dc, input logic [DW-1:0] v, input logic csa,
                           input logic csb, input bit expected, input string tag);
        if (expected) expect_word(dc, v, tag);
        bus_dc = dc; bus_d_in = v; cs_a_n = csa; cs_b_n = csb;
        tick(1);
        bus_dir = 1'b0;
        tick(4);
        bus_dir = 1'b1;
        tick(2);
        bus_d_in = 16'hDEAD; bus_dc = ~dc;
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        tick(5);
    endtask

    // split-strobe write ended by chip select first
    task automatic w_split_cs_first(input logic dc, input logic [DW-1:0] v, input string tag);
        expect_word(dc, v, tag);
        bus_dc = dc; bus_d_in = v; cs_a_n = 1'b0; cs_b_n = 1'b0;
        tick(1);
        bus_dir = 1'b0;
        tick(4);
        cs_a_n = 1'b1;
        tick(2);
        bus_d_in = 16'h0BAD; bus_dc = ~dc;
        tick(1);
        bus_dir = 1'b1;
        tick(1);
        cs_b_n = 1'b1;
        tick(5);
    endtask

    // enable-strobe write ended by enable falling
    task automatic w_enab(input logic dc, input logic [DW-1:0] v, input string tag);
        expect_word(dc, v, tag);
        bus_dc = dc; bus_d_in = v; bus_dir = 1'b0; cs_a_n = 1'b0; cs_b_n = 1'b0;
        tick(1);
        bus_strb = 1'b1;
        tick(4);
        bus_strb = 1'b0;
        tick(2);
        bus_d_in = 16'hF00D;
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        tick(1);
        bus_dir = 1'b1;
        tick(5);
    endtask

    task automatic read_split(input logic [DW-1:0] v, input string tag);
        cs_a_n = 1'b0; cs_b_n = 1'b0;
        tick(1);
        bus_strb = 1'b0;
        tick(5);
        @(negedge clk);
        check({tag, " oe during read"}, 32'(bus_d_oe), 32'd1);
        check({tag, " read data"}, 32'(bus_d_out), 32'(v));
        tick(1);
        bus_strb = 1'b1;
        tick(1);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        tick(5);
        @(negedge clk);
        check({tag, " oe after read"}, 32'(bus_d_oe), 32'd0);
        tick(1);
    endtask

    task automatic read_enab(input logic [DW-1:0] v, input string tag);
        bus_dir = 1'b1; cs_a_n = 1'b0; cs_b_n = 1'b0;
        tick(1);
        bus_strb = 1'b1;
        tick(5);
        @(negedge clk);
        check({tag, " oe during read"}, 32'(bus_d_oe), 32'd1);
        check({tag, " read data"}, 32'(bus_d_out), 32'(v));
        tick(1);
        bus_strb = 1'b0;
        tick(1);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        tick(5);
        @(negedge clk);
        check({tag, " oe after read"}, 32'(bus_d_oe), 32'd0);
        tick(1);
    endtask

    task automatic respond(input logic [DW-1:0] v);
        rsp_data = v; rsp_valid = 1'b1;
        tick(1);
        rsp_valid = 1'b0;
        @(negedge clk);
        check("R8 irq raised", 32'(irq), 32'd1);
        tick(1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        tick(3);
        @(negedge clk);
        check("R11 wr_valid", 32'(wr_valid), 32'd0);
        check("R11 irq", 32'(irq), 32'd0);
        check("R11 ovf", 32'(wr_ovf), 32'd0);
        check("R11 oe", 32'(bus_d_oe), 32'd0);
        check("R11 dout", 32'(bus_d_out), 32'd0);
        rst_n = 1'b1;
        tick(3);

        // split-strobe writes
        w_split(1'b1, 16'h1234, 1'b0, 1'b0, 1'b1, "R1/R4 data write");
        w_split(1'b0, 16'h00A5, 1'b0, 1'b0, 1'b1, "R1/R4 command write");
        w_split_cs_first(1'b1, 16'hBEEF, "R1 chip select edge first");
        w_split(1'b1, 16'h7777, 1'b1, 1'b0, 1'b0, "R5");
        w_split(1'b1, 16'h8888, 1'b0, 1'b1, 1'b0, "R5");
        @(negedge clk);
        check("R5 no word from deselected writes", 32'(wr_valid), 32'd0);
        tick(1);

        // read data and interrupt, split style
        respond(16'hCAFE);
        read_split(16'hCAFE, "R6");
        @(negedge clk);
        check("R8 irq after first read", 32'(irq), 32'd1);
        tick(1);
        cs_a_n = 1'b0; cs_b_n = 1'b1;
        tick(1);
        bus_strb = 1'b0;
        tick(5);
        @(negedge clk);
        check("R5 no drive when deselected", 32'(bus_d_oe), 32'd0);
        tick(1);
        bus_strb = 1'b1; cs_a_n = 1'b1; cs_b_n = 1'b1;
        tick(5);
        @(negedge clk);
        check("R5 deselected read not counted", 32'(irq), 32'd1);
        tick(1);
        read_split(16'hCAFE, "R6 second");
        @(negedge clk);
        check("R8 irq after second read", 32'(irq), 32'd0);
        tick(1);

        // restart of the read count
        respond(16'h5555);
        read_split(16'h5555, "R6");
        respond(16'h6666);
        read_split(16'h6666, "R6");
        @(negedge clk);
        check("R8 restart keeps irq", 32'(irq), 32'd1);
        tick(1);
        read_split(16'h6666, "R6");
        @(negedge clk);
        check("R8 irq after restart count", 32'(irq), 32'd0);
        tick(1);

        // stall and overflow
        wr_ready = 1'b0;
        w_split(1'b1, 16'h1111, 1'b0, 1'b0, 1'b1, "R9 held word");
        w_split(1'b0, 16'h2222, 1'b0, 1'b0, 1'b0, "R10");
        @(negedge clk);
        check("R10 overflow set", 32'(wr_ovf), 32'd1);
        check("R9 valid held", 32'(wr_valid), 32'd1);
        check("R10 held word unchanged", 32'({wr_cmd, wr_data}), 32'({1'b0, 16'h1111}));
        tick(1);
        wr_ready = 1'b1;
        tick(4);
        @(negedge clk);
        check("R10 overflow sticky", 32'(wr_ovf), 32'd1);
        check("R9 slot drained", 32'(wr_valid), 32'd0);
        tick(1);

        // enable-strobe style
        bus_strb = 1'b0; bus_dir = 1'b1;
        tick(1);
        mode_split = 1'b0;
        tick(3);
        w_enab(1'b1, 16'h4321, "R2/R4 data write");
        w_enab(1'b0, 16'h0077, "R2/R4 command write");

        // enable held high, chip select ends the write
        expect_word(1'b1, 16'h9999, "R3 enable static");
        bus_dc = 1'b1; bus_d_in = 16'h9999; bus_dir = 1'b0;
        tick(1);
        bus_strb = 1'b1; cs_a_n = 1'b0; cs_b_n = 1'b0;
        tick(4);
        cs_b_n = 1'b1;
        tick(2);
        bus_d_in = 16'h0F0F; cs_a_n = 1'b1;
        tick(1);
        bus_dir = 1'b1;
        tick(1);
        bus_strb = 1'b0;
        tick(5);

        // abort: direction rises with enable high
        bus_d_in = 16'h3333; bus_dir = 1'b0;
        tick(1);
        bus_strb = 1'b1; cs_a_n = 1'b0; cs_b_n = 1'b0;
        tick(4);
        bus_dir = 1'b1;
        tick(4);
        bus_strb = 1'b0;
        tick(1);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
        tick(5);
        @(negedge clk);
        check("R12 aborted write gives no word", 32'(wr_valid), 32'd0);
        tick(1);

        // enable-strobe reads
        respond(16'hABCD);
        read_enab(16'hABCD, "R7");
        @(negedge clk);
        check("R8 irq after first enable read", 32'(irq), 32'd1);
        tick(1);
        read_enab(16'hABCD, "R7 second");
        @(negedge clk);
        check("R8 irq after second enable read", 32'(irq), 32'd0);
        tick(1);

        tick(10);
        check("R9 all expected words delivered", 32'(exp_q.size()), 32'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule